// File: doc/BRIEF.md
# Three-Mode PWM Timebase Counter

This block is the time reference for a pulse-width modulation channel. A 16-bit counter steps once per prescaled tick. The tick rate is the input clock divided by the prescale setting plus one. Against a programmable period the counter can rise and wrap, fall and reload, or rise and then fall in a triangle. Downstream comparators take the count, its direction, and two event strobes. One strobe marks entry into zero and the other marks entry into the period value.

The configuration is applied immediately and is never double-buffered. Writing a new period or prescale changes the behaviour on the next tick. A software sync works by toggling a single input bit. Each change of that bit loads a phase value and a direction into the counter. A stopped or frozen timer still accepts a sync. A frozen timer holds its count and emits no strobes.

Top module: `pwm_timebase`

## Requirements
- R1: While reset is asserted, and directly after it, the count is 0, the direction is increasing (0), and both strobes are low.
- R2: With prescale value P, a running counter changes value once every P+1 clock cycles. A sync restarts this division.
- R3: With mode code 1 (count up), the count steps 0, 1, …, period and then returns to 0, so one cycle is period+1 ticks. The direction reads 0.
- R4: With mode code 2 (count down), the count steps period, …, 1, 0 and then reloads period, so one cycle is period+1 ticks. The direction reads 1.
- R5: With mode code 3 (up-down), the count rises from 0 to period and then falls back to 0. Each turning point lasts one tick, so one cycle is 2×period ticks. The direction reads 0 while rising and 1 while falling. A period of 0 holds the count at 0.
- R6: The counter holds its value, and emits no strobe, in two cases: when the mode code is 0 (freeze), or when the start field is any value other than 2 (run continuously).
- R7: Any change of the sync toggle input loads the phase value into the count and the phase direction bit into the direction (1 = decreasing). The load happens one clock later, in every mode, including freeze.
- R8: The zero strobe is high for exactly one clock when the count takes the value 0. The period strobe is high for exactly one clock when the count takes the period value. Both strobes coincide with the first clock of the new value.
- R9: A period or prescale change takes effect at once. A count found above the new period wraps to 0 in up mode and reloads the period in down mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prescale | input | 8 | Tick divider minus one |
| cfg_period | input | 16 | Period value |
| cfg_mode | input | 2 | 0 freeze, 1 up, 2 down, 3 up-down |
| cfg_start | input | 2 | Value 2 runs continuously, other values hold |
| sync_toggle | input | 1 | Software sync; each change loads the phase |
| sync_phase | input | 16 | Count loaded on sync |
| sync_dir | input | 1 | Direction loaded on sync, 1 = decreasing |
| cnt_value | output | 16 | Current count |
| cnt_dir | output | 1 | Current direction, 1 = decreasing |
| evt_zero | output | 1 | Strobe on entry into count 0 |
| evt_period | output | 1 | Strobe on entry into count = period |

## Verification
Suppose the prescale divider holds a wrong state. The count then steps at an uneven spacing, and the scoreboard sees this on the first tick that arrives early or late, which is at most prescale+1 clocks away. A wrong direction bit shows on `cnt_dir` at the same clock. In up-down mode it also shows one tick later as a step the wrong way. A missed turning point sends the count past the period, and the period strobe fails to appear in the expected clock. A wrong sync edge memory shows as a phase load that is missing or extra on the clock after the toggle.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
  typedef enum logic [1:0] {
    MODE_FREEZE = 2'd0,
    MODE_UP     = 2'd1,
    MODE_DOWN   = 2'd2,
    MODE_UPDOWN = 2'd3
  } tb_mode_e;

  localparam int unsigned START_W   = 2;
  localparam logic [START_W-1:0] START_RUN = 2'd2;
endpackage

// File: rtl/pwm_sync_edge.sv
module pwm_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle_in,
  output logic sync_evt
);
  logic seen_q;

  assign sync_evt = toggle_in ^ seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= toggle_in;
  end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             restart,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    tick = active && !restart && (pre_q >= div);
    if (!active || restart || tick) pre_d = '0;
    else                            pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  p_tick_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre_q == '0));
  p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (pre_q == '0));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_tb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sync_evt,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] phase,
  input  logic             phase_dir,
  output logic [CNT_W-1:0] cnt,
  output logic             dir,
  output logic             load,
  output logic [CNT_W-1:0] cnt_next
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    load  = 1'b0;
    if (sync_evt) begin
      cnt_d = phase;
      dir_d = phase_dir;
      load  = 1'b1;
    end else if (tick) begin
      load = 1'b1;
      case (tb_mode_e'(mode))
        MODE_UP: begin
          dir_d = 1'b0;
          cnt_d = (cnt_q >= period) ? '0 : cnt_q + 1'b1;
        end
        MODE_DOWN: begin
          dir_d = 1'b1;
          cnt_d = (cnt_q == '0 || cnt_q > period) ? period : cnt_q - 1'b1;
        end
        MODE_UPDOWN: begin
          if (period == '0) begin
            cnt_d = '0;
            dir_d = 1'b0;
          end else if (!dir_q) begin
            if (cnt_q >= period) begin
              cnt_d = period - 1'b1;
              dir_d = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            if (cnt_q == '0) begin
              cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
              dir_d = 1'b0;
            end else if (cnt_q > period) begin
              cnt_d = period;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default: load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt      = cnt_q;
  assign dir      = dir_q;
  assign cnt_next = cnt_d;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sync_evt) |=> $stable(cnt_q) && $stable(dir_q));
  p_sync_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> (cnt_q == $past(phase)) && (dir_q == $past(phase_dir)));
  p_up_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sync_evt && mode == MODE_UP) |=> !dir_q);
  p_down_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sync_evt && mode == MODE_DOWN) |=> dir_q);
  p_updown_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sync_evt && mode == MODE_UPDOWN && period != '0 && cnt_q <= period)
      |=> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pwm_events.sv
module pwm_events #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [CNT_W-1:0] period,
  output logic             evt_zero,
  output logic             evt_period
);
  logic ez_q, ez_d, ep_q, ep_d;

  always_comb begin
    ez_d = load && (cnt_next == '0);
    ep_d = load && (cnt_next == period);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ez_q <= 1'b0;
      ep_q <= 1'b0;
    end else begin
      ez_q <= ez_d;
      ep_q <= ep_d;
    end
  end

  assign evt_zero   = ez_q;
  assign evt_period = ep_q;

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (!ez_q && !ep_q));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRE_W-1:0]   cfg_prescale,
  input  logic [CNT_W-1:0]   cfg_period,
  input  logic [1:0]         cfg_mode,
  input  logic [START_W-1:0] cfg_start,
  input  logic               sync_toggle,
  input  logic [CNT_W-1:0]   sync_phase,
  input  logic               sync_dir,
  output logic [CNT_W-1:0]   cnt_value,
  output logic               cnt_dir,
  output logic               evt_zero,
  output logic               evt_period
);
  logic             active, tick, sync_evt, load;
  logic [CNT_W-1:0] cnt_next;

  assign active = (cfg_mode != MODE_FREEZE) && (cfg_start == START_RUN);

  pwm_sync_edge u_sync (
    .clk(clk), .rst_n(rst_n), .toggle_in(sync_toggle), .sync_evt(sync_evt)
  );

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .active(active), .restart(sync_evt),
    .div(cfg_prescale), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sync_evt(sync_evt),
    .mode(cfg_mode), .period(cfg_period), .phase(sync_phase),
    .phase_dir(sync_dir), .cnt(cnt_value), .dir(cnt_dir),
    .load(load), .cnt_next(cnt_next)
  );

  pwm_events #(.CNT_W(CNT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .load(load), .cnt_next(cnt_next),
    .period(cfg_period), .evt_zero(evt_zero), .evt_period(evt_period)
  );

  p_zero_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_zero |-> (cnt_value == '0));
  p_period_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_period) |-> (cnt_value == $past(cfg_period)));
  p_up_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sync_evt && cfg_mode == MODE_UP && cnt_value > cfg_period)
      |=> (cnt_value == $past(cnt_value)) || (cnt_value == '0));
endmodule

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_prescale;
  logic [15:0] cfg_period;
  logic [1:0]  cfg_mode;
  logic [1:0]  cfg_start;
  logic        sync_toggle;
  logic [15:0] sync_phase;
  logic        sync_dir;
  logic [15:0] cnt_value;
  logic        cnt_dir, evt_zero, evt_period;

  int total = 0;
  int bad   = 0;
  string cur_req = "R1";
  logic [18:0] sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timebase u0 (
    .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale), .cfg_period(cfg_period),
    .cfg_mode(cfg_mode), .cfg_start(cfg_start), .sync_toggle(sync_toggle),
    .sync_phase(sync_phase), .sync_dir(sync_dir), .cnt_value(cnt_value),
    .cnt_dir(cnt_dir), .evt_zero(evt_zero), .evt_period(evt_period)
  );

  // expected-value producer, built from the requirements
  logic [15:0] m_cnt;
  logic [7:0]  m_pre;
  logic        m_dir, m_sq, m_ez, m_ep, m_act, m_sy, m_tk, m_ld;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_dir = 0; m_pre = 0; m_sq = 0; m_ez = 0; m_ep = 0;
    end else begin
      m_act = (cfg_mode != 2'd0) && (cfg_start == 2'd2);
      m_sy  = (sync_toggle != m_sq);
      m_sq  = sync_toggle;
      m_tk  = m_act && !m_sy && (m_pre >= cfg_prescale);
      m_ld  = 1'b0;
      if (m_sy) begin
        m_cnt = sync_phase; m_dir = sync_dir; m_ld = 1'b1; m_pre = 0;
      end else begin
        if (!m_act || m_tk) m_pre = 0; else m_pre = m_pre + 8'd1;
        if (m_tk) begin
          m_ld = 1'b1;
          if (cfg_mode == 2'd1) begin
            m_dir = 0;
            m_cnt = (m_cnt >= cfg_period) ? 16'd0 : m_cnt + 16'd1;
          end else if (cfg_mode == 2'd2) begin
            m_dir = 1;
            m_cnt = (m_cnt == 0 || m_cnt > cfg_period) ? cfg_period : m_cnt - 16'd1;
          end else begin
            if (cfg_period == 0) begin m_cnt = 0; m_dir = 0; end
            else if (!m_dir) begin
              if (m_cnt >= cfg_period) begin m_cnt = cfg_period - 16'd1; m_dir = 1; end
              else m_cnt = m_cnt + 16'd1;
            end else begin
              if (m_cnt == 0) begin m_cnt = 16'd1; m_dir = 0; end
              else if (m_cnt > cfg_period) m_cnt = cfg_period;
              else m_cnt = m_cnt - 16'd1;
            end
          end
        end
      end
      m_ez = m_ld && (m_cnt == 0);
      m_ep = m_ld && (m_cnt == cfg_period);
    end
    sb_q.push_back({m_cnt, m_dir, m_ez, m_ep});
  end

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      logic [18:0] exp_v;
      exp_v = sb_q.pop_front();
      total++;
      if ({cnt_value, cnt_dir, evt_zero, evt_period} !== exp_v) begin
        bad++;
        $display("FAIL %s: cnt=%0d dir=%0b ez=%0b ep=%0b expected cnt=%0d dir=%0b ez=%0b ep=%0b",
                 cur_req, cnt_value, cnt_dir, evt_zero, evt_period,
                 exp_v[18:3], exp_v[2], exp_v[1], exp_v[0]);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic direct_chk(input string req, input logic [15:0] act, input logic [15:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    int zc;
    rst_n = 0; cfg_prescale = 0; cfg_period = 5; cfg_mode = 0; cfg_start = 0;
    sync_toggle = 0; sync_phase = 0; sync_dir = 0;
    cur_req = "R1";
    idle(4);
    direct_chk("R1", {cnt_value[14:0], cnt_dir}, 16'd0);
    rst_n = 1;
    idle(3);
    direct_chk("R1", {13'd0, cnt_dir, evt_zero, evt_period}, 16'd0);

    cur_req = "R3"; cfg_mode = 2'd1; cfg_start = 2'd2;
    zc = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (evt_zero) zc++; end
    direct_chk("R3", zc[15:0], 16'd10);

    cur_req = "R2"; cfg_prescale = 8'd3; idle(40);
    cfg_prescale = 8'd0;

    cur_req = "R4"; cfg_mode = 2'd2; cfg_period = 6; idle(25);

    cur_req = "R5"; cfg_mode = 2'd3; cfg_period = 4; idle(25);
    cfg_prescale = 8'd1; idle(30);
    cfg_prescale = 8'd0; cfg_period = 0; idle(6);
    cfg_period = 4;

    cur_req = "R6"; cfg_mode = 2'd0; idle(10);
    cfg_mode = 2'd1; cfg_start = 2'd1; idle(10);
    cfg_start = 2'd0; idle(5);
    cfg_start = 2'd2;

    cur_req = "R7"; cfg_mode = 2'd3; sync_phase = 16'd3; sync_dir = 1;
    sync_toggle = ~sync_toggle; idle(12);
    cfg_mode = 2'd0; sync_phase = 16'd9; sync_dir = 0;
    sync_toggle = ~sync_toggle; idle(2);
    direct_chk("R7", cnt_value, 16'd9);
    idle(4);
    direct_chk("R7", cnt_value, 16'd9);
    cfg_mode = 2'd1; cfg_prescale = 8'd2; sync_phase = 16'd1;
    sync_toggle = ~sync_toggle; idle(12);
    cfg_prescale = 8'd0;

    cur_req = "R9"; cfg_mode = 2'd1; cfg_period = 20; idle(15);
    cfg_period = 4; idle(10);
    cfg_mode = 2'd2; cfg_period = 20; idle(6);
    cfg_period = 3; idle(10);

    cur_req = "R8"; cfg_mode = 2'd1; cfg_period = 0; idle(6);
    cfg_mode = 2'd2; cfg_period = 1; cfg_prescale = 8'd1; idle(12);

    idle(2);
    finish_run();
  end
endmodule